// File: doc/BRIEF.md
# Watchdog Timer with Keyed Disable

This block is a watchdog counter on a small synchronous register bus. It starts counting when reset is released. If software does nothing, it raises a one-cycle system-reset request each time the count runs out. Software stops it by writing two fixed key words, in order, to a control register. Each write to that register is posted: it completes a fixed number of cycles later. A busy flag in a status register shows that a write is still in flight, and software polls that flag before it writes the next key.

A second ordered key pair starts a stopped watchdog again from its full timeout. Any other value written after the first stop key cancels the stop attempt. The counter then keeps its state, and the decoder waits for the first key again. The timeout is a parameter with a small default so that simulation stays short.

Top module: `wdog_keyed`

## Requirements
- R1: During reset and in the first cycle after it, rst_req is 0. A read of offset 0x48 returns 0, and a read of offset 0x34 returns 0. The watchdog is running.
- R2: While the watchdog runs and is not stopped, rst_req is high for exactly one cycle once every TIMEOUT cycles, and the counter reloads at each pulse. The first pulse follows the edge that is TIMEOUT clock edges after reset release.
- R3: A write to offset 0x48 is accepted when no write is pending. The following cycle, a read of 0x48 returns the written value. Bit 4 of offset 0x34 then reads 1 for exactly PEND_CYC (default 4) cycles.
- R4: A write to 0x48 while bit 4 of 0x34 is 1 is dropped. It changes neither the read-back value nor the pending window, and it is never applied.
- R5: The value 0xAAAA applied first, then 0x5555 applied next, stops the watchdog. After that, rst_req stays 0.
- R6: A posted write is applied at the clock edge where its pending bit clears. That edge is the PEND_CYC-th edge after the edge that accepted it, and a stop or restart takes effect at that same edge.
- R7: If the value applied after 0xAAAA is not 0x5555, the attempt is cancelled. The watchdog keeps running, and a later lone 0x5555 has no effect.
- R8: The value 0xBBBB applied first, then 0x4444 applied next, restarts a stopped watchdog with the counter at its full value. The next rst_req pulse follows the edge that is TIMEOUT edges after the applying edge.
- R9: A read of any offset other than 0x48 and 0x34 returns 0. At 0x34, every bit other than bit 4 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Byte offset of the register access |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| rst_req | output | 1 | One-cycle system-reset request |

## Verification
Read data is combinational from the address, so a read reflects the state left by the previous edge. A control write shows in read-back one cycle after its accepting edge. The pending bit is high for the next PEND_CYC cycles, and the key is applied at the PEND_CYC-th edge. An expiry appears on rst_req in the cycle after the edge where the count was zero. The bench drives inputs just after the falling edge. It steps a behavioural model on each rising edge, using the same sampled inputs, and compares rst_req and bus_rdata against the model at every falling edge, so each result is taken in the cycle it is due. Windowed pulse counts after reset, after a stop and after a restart add checks on the expiry period that do not depend on the model.

// File: rtl/wdk_pkg.sv
package wdk_pkg;

    localparam logic [7:0]  OFS_CTRL   = 8'h48;
    localparam logic [7:0]  OFS_STAT   = 8'h34;
    localparam int          BUSY_BIT   = 4;

    localparam logic [15:0] KEY_STOP_A = 16'hAAAA;
    localparam logic [15:0] KEY_STOP_B = 16'h5555;
    localparam logic [15:0] KEY_RUN_A  = 16'hBBBB;
    localparam logic [15:0] KEY_RUN_B  = 16'h4444;

    typedef enum logic [1:0] {
        KS_IDLE = 2'd0,
        KS_STOP = 2'd1,
        KS_RUN  = 2'd2
    } key_state_e;

    typedef struct packed {
        logic stop;
        logic start;
    } key_cmd_t;

    function automatic logic key_is(input logic [31:0] v, input logic [15:0] k);
        return v == {16'h0000, k};
    endfunction

endpackage

// File: rtl/wdk_regs.sv
module wdk_regs
    import wdk_pkg::*;
#(
    parameter int AW       = 8,
    parameter int DW       = 32,
    parameter int PEND_CYC = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] bus_addr,
    input  logic          bus_wr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic          apply,
    output logic [DW-1:0] ctrl_val
);
    localparam int PW = $clog2(PEND_CYC + 1);
    localparam logic [PW-1:0] PEND_LOAD = PW'(PEND_CYC);

    logic [PW-1:0] pend_cnt;
    logic          pending;
    logic          accept;

    assign pending = (pend_cnt != '0);
    assign accept  = bus_wr && (bus_addr == AW'(OFS_CTRL)) && !pending;
    assign apply   = (pend_cnt == PW'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_cnt <= '0;
            ctrl_val <= '0;
        end else if (pending) begin
            pend_cnt <= pend_cnt - PW'(1);
        end else if (accept) begin
            pend_cnt <= PEND_LOAD;
            ctrl_val <= bus_wdata;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == AW'(OFS_CTRL))
            bus_rdata = ctrl_val;
        else if (bus_addr == AW'(OFS_STAT))
            bus_rdata[BUSY_BIT] = pending;
    end

    // R6: the edge that applies a write also ends its pending window
    p_apply_clears_r6: assert property (@(posedge clk) disable iff (rst)
        apply |=> !pending);

    // R4: a write arriving while busy leaves the stored value alone
    p_busy_write_dropped_r4: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && pending) |=> $stable(ctrl_val));

    // R3: an accepted write opens a pending window
    p_accept_pends_r3: assert property (@(posedge clk) disable iff (rst)
        accept |=> pending);

endmodule

// File: rtl/wdk_keyseq.sv
module wdk_keyseq
    import wdk_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          apply,
    input  logic [DW-1:0] val,
    output key_cmd_t      cmd
);
    key_state_e state, state_nx;
    logic [31:0] v32;

    assign v32 = 32'(val);

    always_comb begin
        state_nx  = state;
        cmd.stop  = 1'b0;
        cmd.start = 1'b0;
        if (apply) begin
            unique case (state)
                KS_IDLE: begin
                    if (key_is(v32, KEY_STOP_A))     state_nx = KS_STOP;
                    else if (key_is(v32, KEY_RUN_A)) state_nx = KS_RUN;
                    else                             state_nx = KS_IDLE;
                end
                KS_STOP: begin
                    cmd.stop = key_is(v32, KEY_STOP_B);
                    state_nx = KS_IDLE;
                end
                KS_RUN: begin
                    cmd.start = key_is(v32, KEY_RUN_B);
                    state_nx  = KS_IDLE;
                end
                default: state_nx = KS_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state <= KS_IDLE;
        else     state <= state_nx;
    end

    // R7: commands only come out on an applying edge, never both at once
    p_cmd_exclusive_r7: assert property (@(posedge clk) disable iff (rst)
        $onehot0({cmd.stop, cmd.start}) && ((cmd.stop || cmd.start) -> apply));

    // R7: after any applied second word the decoder is back to idle
    p_second_word_idles_r7: assert property (@(posedge clk) disable iff (rst)
        (apply && state != KS_IDLE) |=> state == KS_IDLE);

endmodule

// File: rtl/wdk_counter.sv
module wdk_counter
    import wdk_pkg::*;
#(
    parameter int TIMEOUT = 64
) (
    input  logic     clk,
    input  logic     rst,
    input  key_cmd_t cmd,
    output logic     rst_req
);
    localparam int CW = (TIMEOUT > 2) ? $clog2(TIMEOUT) : 1;
    localparam logic [CW-1:0] RELOAD = CW'(TIMEOUT - 1);

    logic [CW-1:0] cnt;
    logic          run;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= RELOAD;
            run     <= 1'b1;
            rst_req <= 1'b0;
        end else begin
            rst_req <= 1'b0;
            if (cmd.start && !run) begin
                run <= 1'b1;
                cnt <= RELOAD;
            end else if (cmd.stop) begin
                run <= 1'b0;
            end else if (run) begin
                if (cnt == '0) begin
                    rst_req <= 1'b1;
                    cnt     <= RELOAD;
                end else begin
                    cnt <= cnt - CW'(1);
                end
            end
        end
    end

    // R2: the request is a single-cycle pulse
    p_single_pulse_r2: assert property (@(posedge clk) disable iff (rst)
        rst_req |=> !rst_req);

    // R5: a stopped watchdog raises no request
    p_quiet_when_stopped_r5: assert property (@(posedge clk) disable iff (rst)
        !run |=> !rst_req);

    // R8: a restart leaves the counter at its full value
    p_restart_full_r8: assert property (@(posedge clk) disable iff (rst)
        (cmd.start && !run) |=> (run && cnt == RELOAD));

endmodule

// File: rtl/wdog_keyed.sv
module wdog_keyed
    import wdk_pkg::*;
#(
    parameter int TIMEOUT  = 64,
    parameter int PEND_CYC = 4,
    parameter int AW       = 8,
    parameter int DW       = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] bus_addr,
    input  logic          bus_wr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic          rst_req
);
    logic          apply;
    logic [DW-1:0] ctrl_val;
    key_cmd_t      cmd;

    wdk_regs #(.AW(AW), .DW(DW), .PEND_CYC(PEND_CYC)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .apply     (apply),
        .ctrl_val  (ctrl_val)
    );

    wdk_keyseq #(.DW(DW)) u_keyseq (
        .clk   (clk),
        .rst   (rst),
        .apply (apply),
        .val   (ctrl_val),
        .cmd   (cmd)
    );

    wdk_counter #(.TIMEOUT(TIMEOUT)) u_counter (
        .clk     (clk),
        .rst     (rst),
        .cmd     (cmd),
        .rst_req (rst_req)
    );

endmodule

// File: tb/wdog_keyed_bench.sv
`timescale 1ns/1ps
module wdog_keyed_bench;
    localparam int T = 64;
    localparam int P = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  bus_addr = 8'h00;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        rst_req;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    string cur_tag = "R1";

    // model state
    int          m_cnt, m_pend, m_stage;
    bit          m_run, m_req;
    logic [31:0] m_val;

    always #5 clk = ~clk;

    wdog_keyed #(.TIMEOUT(T), .PEND_CYC(P)) u_wdog_keyed (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rst_req(rst_req)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    function automatic logic [31:0] m_read(input logic [7:0] a);
        if (a == 8'h48) return m_val;
        if (a == 8'h34) return (m_pend != 0) ? 32'h10 : 32'h0;
        return 32'h0;
    endfunction

    always @(posedge clk) begin
        cyc++;
        if (rst) begin
            m_cnt = T - 1; m_run = 1; m_req = 0; m_pend = 0; m_val = 0; m_stage = 0;
        end else begin
            bit ap, stp, sta;
            ap  = (m_pend == 1);
            stp = ap && m_stage == 1 && m_val == 32'h5555;
            sta = ap && m_stage == 2 && m_val == 32'h4444 && !m_run;
            if (ap) begin
                if (m_stage != 0)            m_stage = 0;
                else if (m_val == 32'hAAAA)  m_stage = 1;
                else if (m_val == 32'hBBBB)  m_stage = 2;
            end
            m_req = 0;
            if (sta) begin
                m_run = 1; m_cnt = T - 1;
            end else if (stp) begin
                m_run = 0;
            end else if (m_run) begin
                if (m_cnt == 0) begin m_req = 1; m_cnt = T - 1; end
                else m_cnt--;
            end
            if (m_pend > 0) m_pend--;
            else if (bus_wr && bus_addr == 8'h48) begin
                m_pend = P; m_val = bus_wdata;
            end
        end
    end

    always @(negedge clk) begin
        check({cur_tag, " rst_req"}, {31'b0, rst_req}, {31'b0, m_req});
        check({cur_tag, " rdata"}, bus_rdata, m_read(bus_addr));
        if (cyc > 20000) begin
            n_bad++;
            $display("FAIL watchdog: run hung, actual %0d cycles expected < 20000", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    task automatic wr_ctrl(input logic [31:0] v);
        @(negedge clk); #1;
        bus_addr = 8'h48; bus_wr = 1'b1; bus_wdata = v;
        @(negedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic poll_idle();
        @(negedge clk); #1;
        bus_addr = 8'h34;
        do @(negedge clk); while (bus_rdata[4] === 1'b1);
    endtask

    task automatic count_pulses(input int n, output int hits);
        hits = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (rst_req === 1'b1) hits++;
        end
    endtask

    initial begin
        int hits;
        repeat (3) @(negedge clk);
        // R1: reset state
        bus_addr = 8'h48; #1;
        check("R1 ctrl during reset", bus_rdata, 32'h0);
        bus_addr = 8'h34; #1;
        check("R1 status during reset", bus_rdata, 32'h0);
        check("R1 rst_req during reset", {31'b0, rst_req}, 32'h0);
        rst = 1'b0;

        // R2: free-running expiry period
        cur_tag = "R2";
        count_pulses(2 * T + 3, hits);
        check("R2 pulses in two periods", hits, 2);

        // R3, R4: write accepted, second write while busy dropped
        cur_tag = "R3";
        wr_ctrl(32'hAAAA);
        cur_tag = "R4";
        bus_addr = 8'h48; bus_wr = 1'b1; bus_wdata = 32'h1234;
        @(negedge clk); #1;
        bus_wr = 1'b0;
        @(negedge clk);
        check("R4 busy write ignored", bus_rdata, 32'hAAAA);
        poll_idle();

        // R5, R6: stop key completes the sequence
        cur_tag = "R6";
        wr_ctrl(32'h5555);
        poll_idle();
        cur_tag = "R5";
        count_pulses(3 * T, hits);
        check("R5 no pulse while stopped", hits, 0);

        // R8: restart from full timeout
        cur_tag = "R8";
        wr_ctrl(32'hBBBB);
        poll_idle();
        wr_ctrl(32'h4444);
        poll_idle();
        count_pulses(2 * T, hits);
        check("R8 pulses after restart", hits, 2);

        // R7: cancelled stop attempt, then a lone second key
        cur_tag = "R7";
        wr_ctrl(32'hAAAA);
        poll_idle();
        wr_ctrl(32'h1111);
        poll_idle();
        wr_ctrl(32'h5555);
        poll_idle();
        count_pulses(T + 2, hits);
        check("R7 still running", {31'b0, hits > 0}, 32'h1);

        // R9: unmapped offsets read zero
        cur_tag = "R9";
        bus_addr = 8'h00; #1;
        check("R9 offset 0x00", bus_rdata, 32'h0);
        bus_addr = 8'h4C; #1;
        check("R9 offset 0x4C", bus_rdata, 32'h0);
        bus_addr = 8'h35; #1;
        check("R9 offset 0x35", bus_rdata, 32'h0);
        repeat (4) @(negedge clk);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule